// File: doc/BRIEF.md
# Multi-Source Wake Controller

This block gathers wake requests while the device sits in a low-power state. The requests come from five external pins and from an internal countdown timer. Two general-purpose pins wake on a high level. One general-purpose pin and the serial receive pin wake on a rising edge. The push-button pin must stay high across a run of slow sample strobes before it counts. Each source records its cause in a sticky flag. The single `wake_o` output is the OR of the pending wake-source flags, and it is only asserted while the low-power input is high. Four further flags, which are always enabled, record reset causes and supply events that arrive as one-cycle strobes.

Software reaches the block through a small word-wide register port. Register 0 holds the per-source enables and the timer-arm bit. Register 1 holds the timer reload value. Register 2 holds the flags, which are cleared by writing 1 to a bit. Register 3 reads back the live timer count. Every pin input passes through a two-flop synchronizer before it is detected.

Top module: `wake_ctrl`

## Requirements
- R1: Level pins 0 and 1 (`pin_lvl_i[0]`, `pin_lvl_i[1]`) set flag bits 1 and 2. A flag is set in every cycle in which the synchronized pin is high and the source is effective. A source is effective when its enable bit (bit 1 or bit 2 of register 0) is set and its `pin_is_input_i` bit (bit 1 or bit 2) is set. The flag appears three clock edges after the pin changes.
- R2: The edge pin (`pin_edge_i`, enable bit 0, config bit 0) sets flag bit 0, and the receive pin (`rx_i`, enable bit 4) sets flag bit 4. Each is set only on a synchronized low-to-high transition seen while the source is effective. A pin that is already high when it becomes enabled sets nothing.
- R3: The flag of a pin source reads 0 one cycle after that source stops being effective, even if the flag was set before. For the three general-purpose pins, an enable bit whose config bit is 0 has no effect.
- R4: The push-button (`pb_i`, enable bit 3, flag bit 3) is sampled on each `deb_tick_i` pulse. It counts as high only after DEB_SAMPLES (default 32) consecutive high samples, and any low sample restarts the count.
- R5: Writing register 0 with bit 5 = 1 loads the timer from register 1 and arms it. Writing register 0 with bit 5 = 0 disarms it. An armed timer decrements on each `tick_ms_i` pulse, but only while `lp_mode_i` is high. On the tick that would take the count to 0, or on any tick when the count is already 0, the count becomes 0, flag bit 5 is set and the timer disarms. Register 0 bit 5 reads the armed state. Register 3 reads the count.
- R6: The one-cycle strobes `wdt_ev_i`, `cold_ev_i`, `vbat_ev_i` and `rst_ev_i` set flag bits 6, 7, 8 and 9. These flags need no enable.
- R7: Writing register 2 clears each flag bit written as 1. If a set event for a bit falls on the same edge as its clear, the bit stays set.
- R8: `wake_o` is high exactly when `lp_mode_i` is high and any of flag bits 0 to 5 is set. Flag bits 6 to 9 never drive `wake_o`.
- R9: After reset, all registers, flags and the timer read 0, and `wake_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_mode_i | input | 1 | Sleep or display-only mode is active |
| tick_ms_i | input | 1 | Timer decrement pulse |
| deb_tick_i | input | 1 | Push-button sample pulse |
| pin_edge_i | input | 1 | Rising-edge wake pin (async) |
| pin_lvl_i | input | 2 | High-level wake pins (async) |
| pb_i | input | 1 | Push-button pin (async) |
| rx_i | input | 1 | Serial receive pin (async) |
| pin_is_input_i | input | 3 | Digital-input config for edge pin, level pin 0, level pin 1 |
| wdt_ev_i | input | 1 | Watchdog reset strobe |
| cold_ev_i | input | 1 | Cold start strobe |
| vbat_ev_i | input | 1 | Low backup-battery strobe |
| rst_ev_i | input | 1 | Reset pin / software reset strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data (combinational) |
| wake_o | output | 1 | Wake request |

## Verification
Two events can land on the same clock edge: a write-1 clear of a flag and a fresh set event for that same flag. The bench creates this collision twice. In the first case a level pin is held high while its flag is cleared. In the second case a timer tick that expires the count is driven in the same cycle as the clear write for the timer flag. In both cases the flag must still read 1 afterwards, and a plain clear with no competing event must read 0.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int FLAG_W = 10;
  localparam int EN_W   = 5;

  localparam int B_EDGE = 0;
  localparam int B_LVL0 = 1;
  localparam int B_LVL1 = 2;
  localparam int B_PB   = 3;
  localparam int B_RX   = 4;
  localparam int B_TMR  = 5;
  localparam int B_WDT  = 6;
  localparam int B_COLD = 7;
  localparam int B_VBAT = 8;
  localparam int B_RST  = 9;

  localparam int B_ARM  = 5;

  localparam logic [1:0] A_EN     = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_FLAGS  = 2'd2;
  localparam logic [1:0] A_COUNT  = 2'd3;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic din_i,
  output logic valid_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] CMAX = CW'(N);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sample_i) begin
      if (!din_i)            cnt_d = '0;
      else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sample_i) cnt_q <= cnt_d;
  end

  assign valid_o = (cnt_q == CMAX);
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          disarm_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [TW-1:0] cnt_o,
  output logic          armed_o,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          step;

  assign step = armed_q & run_i & tick_i;

  always_comb begin
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    expire_o = 1'b0;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
    end else if (disarm_i) begin
      armed_d = 1'b0;
    end else if (step) begin
      if (cnt_q <= TW'(1)) begin
        cnt_d    = '0;
        armed_d  = 1'b0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i | disarm_i | step) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int DW          = 16,
  parameter int TMR_W       = 16,
  parameter int DEB_SAMPLES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_mode_i,
  input  logic          tick_ms_i,
  input  logic          deb_tick_i,
  input  logic          pin_edge_i,
  input  logic [1:0]    pin_lvl_i,
  input  logic          pb_i,
  input  logic          rx_i,
  input  logic [2:0]    pin_is_input_i,
  input  logic          wdt_ev_i,
  input  logic          cold_ev_i,
  input  logic          vbat_ev_i,
  input  logic          rst_ev_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          wake_o
);
  localparam int NPIN = 5;

  logic [NPIN-1:0]   pin_s;
  logic [1:0]        prev_q;
  logic [EN_W-1:0]   en_q;
  logic [EN_W-1:0]   eff_en;
  logic [TMR_W-1:0]  reload_q;
  logic [FLAG_W-1:0] flags_q, flags_d, flag_set;
  logic              we_en, we_reload, we_flags;
  logic              pb_valid, tmr_expire, tmr_armed;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              rise_edge, rise_rx;

  assign we_en     = reg_we_i & (reg_addr_i == A_EN);
  assign we_reload = reg_we_i & (reg_addr_i == A_RELOAD);
  assign we_flags  = reg_we_i & (reg_addr_i == A_FLAGS);

  wake_sync #(.W(NPIN)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({rx_i, pb_i, pin_lvl_i, pin_edge_i}),
    .q_o   (pin_s)
  );

  wake_debounce #(.N(DEB_SAMPLES)) i_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (deb_tick_i),
    .din_i    (pin_s[B_PB]),
    .valid_o  (pb_valid)
  );

  wake_timer #(.TW(TMR_W)) i_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (we_en & reg_wdata_i[B_ARM]),
    .disarm_i   (we_en & ~reg_wdata_i[B_ARM]),
    .load_val_i (reload_q),
    .run_i      (lp_mode_i),
    .tick_i     (tick_ms_i),
    .cnt_o      (tmr_cnt),
    .armed_o    (tmr_armed),
    .expire_o   (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= {pin_s[B_RX], pin_s[B_EDGE]};
  end

  assign rise_edge = pin_s[B_EDGE] & ~prev_q[0];
  assign rise_rx   = pin_s[B_RX]   & ~prev_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (we_en) en_q <= reg_wdata_i[EN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (we_reload) reload_q <= reg_wdata_i[TMR_W-1:0];
  end

  // General-purpose pins need their digital-input config; PB and RX do not.
  assign eff_en = {en_q[B_RX], en_q[B_PB], en_q[B_LVL1:B_EDGE] & pin_is_input_i};

  always_comb begin
    flag_set         = '0;
    flag_set[B_EDGE] = rise_edge & eff_en[B_EDGE];
    flag_set[B_LVL0] = pin_s[B_LVL0] & eff_en[B_LVL0];
    flag_set[B_LVL1] = pin_s[B_LVL1] & eff_en[B_LVL1];
    flag_set[B_PB]   = pb_valid & eff_en[B_PB];
    flag_set[B_RX]   = rise_rx & eff_en[B_RX];
    flag_set[B_TMR]  = tmr_expire;
    flag_set[B_WDT]  = wdt_ev_i;
    flag_set[B_COLD] = cold_ev_i;
    flag_set[B_VBAT] = vbat_ev_i;
    flag_set[B_RST]  = rst_ev_i;
  end

  always_comb begin
    flags_d = flags_q;
    if (we_flags) flags_d = flags_d & ~reg_wdata_i[FLAG_W-1:0];
    flags_d = flags_d | flag_set;
    flags_d[B_RX:B_EDGE] = flags_d[B_RX:B_EDGE] & eff_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_EN: begin
        reg_rdata_o[EN_W-1:0] = en_q;
        reg_rdata_o[B_ARM]    = tmr_armed;
      end
      A_RELOAD: reg_rdata_o[TMR_W-1:0]  = reload_q;
      A_FLAGS:  reg_rdata_o[FLAG_W-1:0] = flags_q;
      default:  reg_rdata_o[TMR_W-1:0]  = tmr_cnt;
    endcase
  end

  assign wake_o = lp_mode_i & (|flags_q[B_TMR:B_EDGE]);
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk #(
  parameter int DW     = 16,
  parameter int TMR_W  = 16,
  parameter int FLAG_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lp_mode_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [2:0]        pin_is_input_i,
  input logic [4:0]        en_q,
  input logic [FLAG_W-1:0] flags_q,
  input logic [TMR_W-1:0]  tmr_cnt,
  input logic              pb_valid,
  input logic              wake_o
);
  logic wr_en_reg;
  assign wr_en_reg = reg_we_i && (reg_addr_i == 2'd0);

  // R3: a general-purpose pin flag cannot survive loss of effective enable
  p_lvl0_held_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q[1] && pin_is_input_i[1]) |=> !flags_q[1]);

  // R8: no wake outside low-power mode
  p_wake_needs_lp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode_i |-> !wake_o);

  // R8: status-only flags never wake
  p_status_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[5:0] == 6'd0) |-> !wake_o);

  // R7: a status flag stays set until it is written with 1
  p_sticky_wdt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[6] && !(reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[6])) |=> flags_q[6]);

  // R5: the count never rises except through an arm write
  p_count_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_reg |=> (tmr_cnt <= $past(tmr_cnt)));

  // R5: the count is frozen outside low-power mode
  p_count_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_mode_i && !wr_en_reg) |=> $stable(tmr_cnt));

  // R4: the push-button flag only rises after a qualified high
  p_pb_after_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[3]) |-> $past(pb_valid));
endmodule

bind wake_ctrl wake_ctrl_chk #(.DW(DW), .TMR_W(TMR_W), .FLAG_W(wake_pkg::FLAG_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lp_mode_i      (lp_mode_i),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .pin_is_input_i (pin_is_input_i),
  .en_q           (en_q),
  .flags_q        (flags_q),
  .tmr_cnt        (tmr_cnt),
  .pb_valid       (pb_valid),
  .wake_o         (wake_o)
);

// File: tb/test_wake_ctrl.sv
module test_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int MAX_CYC = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lp_mode_i = 1'b0, tick_ms_i = 1'b0, deb_tick_i = 1'b0;
  logic          pin_edge_i = 1'b0, pb_i = 1'b0, rx_i = 1'b0;
  logic [1:0]    pin_lvl_i = '0;
  logic [2:0]    pin_is_input_i = '0;
  logic          wdt_ev_i = 1'b0, cold_ev_i = 1'b0, vbat_ev_i = 1'b0, rst_ev_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          wake_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctrl i_wake_ctrl (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > MAX_CYC) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected below %0d", cyc, MAX_CYC);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic ms_tick();
    @(negedge clk); tick_ms_i = 1'b1;
    @(negedge clk); tick_ms_i = 1'b0;
  endtask

  task automatic deb_tick();
    @(negedge clk); deb_tick_i = 1'b1;
    @(negedge clk); deb_tick_i = 1'b0;
  endtask

  function automatic logic exp_lvl(input logic en, input logic cfg, input logic pin);
    return en & cfg & pin;
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    cyc_wait(3);
    rst_n = 1'b1;
    cyc_wait(1);

    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      check("R9 register after reset", rv, 0);
    end
    check("R9 wake after reset", wake_o, 0);

    // R3: enable without input config has no effect
    pin_lvl_i[0] = 1'b1;
    wr(2'd0, 16'h0002);
    cyc_wait(4);
    rd(2'd2, rv);
    check("R3 lvl0 enabled but not input", rv[1], 0);
    // R1: with config, flag sets
    pin_is_input_i[1] = 1'b1;
    cyc_wait(2);
    rd(2'd2, rv);
    check("R1 lvl0 flag set", rv[1], 1);
    // R7: clear collides with held level, set wins
    wr(2'd2, 16'h0002);
    rd(2'd2, rv);
    check("R7 clear vs held level", rv[1], 1);
    // R3: disabling forces the flag clear
    wr(2'd0, 16'h0000);
    cyc_wait(1);
    rd(2'd2, rv);
    check("R3 flag cleared on disable", rv[1], 0);
    pin_lvl_i[0] = 1'b0;

    // R2: edge pin
    pin_is_input_i[0] = 1'b1;
    wr(2'd0, 16'h0011);
    pin_edge_i = 1'b1;
    cyc_wait(4);
    rd(2'd2, rv);
    check("R2 edge pin rise sets flag", rv[0], 1);
    wr(2'd2, 16'h0001);
    cyc_wait(3);
    rd(2'd2, rv);
    check("R2 steady high does not reset flag", rv[0], 0);
    // R2: rx high before enable
    wr(2'd0, 16'h0001);
    rx_i = 1'b1;
    cyc_wait(4);
    wr(2'd0, 16'h0011);
    cyc_wait(4);
    rd(2'd2, rv);
    check("R2 rx already high when enabled", rv[4], 0);
    rx_i = 1'b0;
    cyc_wait(4);
    rx_i = 1'b1;
    cyc_wait(4);
    rd(2'd2, rv);
    check("R2 rx rise sets flag", rv[4], 1);
    // R8: wake follows lp_mode
    check("R8 no wake outside low-power", wake_o, 0);
    lp_mode_i = 1'b1;
    #1;
    check("R8 wake in low-power", wake_o, 1);
    lp_mode_i = 1'b0;
    wr(2'd0, 16'h0000);
    pin_edge_i = 1'b0; rx_i = 1'b0;
    cyc_wait(2);
    wr(2'd2, 16'h03FF);

    // R4: push-button debounce
    wr(2'd0, 16'h0008);
    pb_i = 1'b1;
    cyc_wait(4);
    for (int i = 0; i < 31; i++) deb_tick();
    cyc_wait(1);
    rd(2'd2, rv);
    check("R4 pb after 31 samples", rv[3], 0);
    pb_i = 1'b0;
    cyc_wait(4);
    deb_tick();
    pb_i = 1'b1;
    cyc_wait(4);
    for (int i = 0; i < 31; i++) deb_tick();
    cyc_wait(1);
    rd(2'd2, rv);
    check("R4 low sample restarts count", rv[3], 0);
    deb_tick();
    cyc_wait(1);
    rd(2'd2, rv);
    check("R4 pb after 32 samples", rv[3], 1);
    pb_i = 1'b0;
    wr(2'd0, 16'h0000);
    cyc_wait(4);

    // R5: timer
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0020);
    rd(2'd3, rv);
    check("R5 arm loads count", rv, 3);
    ms_tick(); ms_tick();
    rd(2'd3, rv);
    check("R5 count frozen outside low-power", rv, 3);
    lp_mode_i = 1'b1;
    ms_tick();
    rd(2'd3, rv);
    check("R5 first decrement", rv, 2);
    ms_tick(); ms_tick();
    rd(2'd3, rv);
    check("R5 expire count", rv, 0);
    rd(2'd2, rv);
    check("R5 timer flag", rv[5], 1);
    rd(2'd0, rv);
    check("R5 disarmed after expire", rv[5], 0);
    check("R8 timer wake", wake_o, 1);
    ms_tick();
    rd(2'd3, rv);
    check("R5 stopped after expire", rv, 0);
    wr(2'd2, 16'h0020);
    rd(2'd2, rv);
    check("R7 plain clear", rv[5], 0);
    // R7: expire and clear on the same edge
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0020);
    @(negedge clk);
    tick_ms_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'h0020;
    @(negedge clk);
    tick_ms_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
    rd(2'd2, rv);
    check("R7 expire wins over clear", rv[5], 1);
    wr(2'd2, 16'h03FF);
    lp_mode_i = 1'b0;

    // R1/R3/R6: random patterns
    for (int it = 0; it < 40; it++) begin
      logic [1:0] en, cfg, pin;
      logic [3:0] st;
      logic [DW-1:0] flags;
      en  = 2'($urandom());
      cfg = 2'($urandom());
      pin = 2'($urandom());
      st  = 4'($urandom());
      pin_is_input_i = {cfg, 1'b0};
      pin_lvl_i = pin;
      wr(2'd0, {13'd0, en, 1'b0});
      cyc_wait(4);
      wr(2'd2, 16'h03FF);
      rd(2'd2, rv);
      check("R1 random lvl0", rv[1], exp_lvl(en[0], cfg[0], pin[0]));
      check("R1 random lvl1", rv[2], exp_lvl(en[1], cfg[1], pin[1]));
      @(negedge clk);
      {rst_ev_i, vbat_ev_i, cold_ev_i, wdt_ev_i} = st;
      @(negedge clk);
      {rst_ev_i, vbat_ev_i, cold_ev_i, wdt_ev_i} = 4'd0;
      rd(2'd2, flags);
      check("R6 random status strobes", flags[9:6], st);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule